// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

This block gathers a set of interrupt inputs and presents one request line to the processor, along with the number of the source that wins arbitration. Each source has its own trigger type, mask bit and 3-bit priority. The trigger type is one of low level, high level, falling edge or rising edge. Every input pin first passes through a two-flop synchronizer. Edge-triggered sources capture their event in a pending latch. Level-triggered sources request for as long as the pin sits at its active level.

The processor acknowledges the presented vector. The controller then pushes that source's priority onto an internal stack of active levels, and from then on only strictly higher priorities can interrupt. An end-of-service pulse pops the stack and restores the previous threshold. This allows nesting up to the number of priority levels.

Configuration (trigger types, masks, priorities) arrives on plain input vectors, so that a surrounding bus wrapper can drive them from its registers.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset, irq_o is 0, nest_busy_o is 0 and nest_lvl_o is 0.
- R2: Trigger field per source (2 bits, source i at bits 2i+1:2i): 00 = low level, 01 = high level, 10 = falling edge, 11 = rising edge. A level source requests while its pin is at the active level and stops requesting when the pin leaves it.
- R3: An edge source latches a pending request on its selected transition. The request remains after the pin returns, and it is cleared only when that source's vector is acknowledged.
- R4: A mask bit of 1 keeps its source out of arbitration. An edge event that arrives while the source is masked is still latched, and it is presented once the mask bit is cleared.
- R5: Among eligible sources, the numerically highest priority wins (7 is highest). Source i's priority is at bits 3i+2:3i.
- R6: Among eligible sources of equal priority, the lowest source number wins.
- R7: An ack_i pulse while irq_o is 1 pushes the presented source's priority. On the next cycle nest_busy_o is 1, nest_lvl_o equals that priority, and irq_o is 0.
- R8: While nest_busy_o is 1, only a source whose priority is strictly greater than nest_lvl_o can raise irq_o.
- R9: An eos_i pulse pops one level and restores the previous threshold. eos_i with an empty stack has no effect. ack_i while irq_o is 0 has no effect. When ack_i and eos_i arrive in the same cycle, only the pop takes place.
- R10: After a pin changes, the resulting irq_o and vec_o are visible within four clock edges. A level source takes three edges: two synchronizer flops and the output register. An edge source takes four, because the pending latch adds one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Raw interrupt pins |
| trig_i | input | 2*NUM_SRC | Trigger type per source |
| mask_i | input | NUM_SRC | 1 = source masked |
| prio_i | input | PRIO_W*NUM_SRC | Priority per source |
| ack_i | input | 1 | Acknowledge of the presented vector |
| eos_i | input | 1 | End of service of the current level |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | $clog2(NUM_SRC) | Winning source number |
| nest_busy_o | output | 1 | At least one level is in service |
| nest_lvl_o | output | PRIO_W | Priority currently in service (0 when idle) |

## Verification
Several faults show up at the ports within four cycles of the stimulus that triggers them:
- A pending latch that clears without an acknowledge makes irq_o drop while the edge source is still owed service.
- A corrupted stack entry shows directly on nest_lvl_o after the next end-of-service pulse.
- A wrong tie-break or a wrong comparison changes vec_o on the first request pattern that holds two candidates.
- A threshold compare using greater-or-equal instead of strictly greater lets irq_o rise during service for a source at the active priority.

Random sequences of pin toggles, reconfiguration, acknowledges and end-of-service pulses are compared against a bench-side model after every step.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        TRIG_LOW_LVL   = 2'b00,
        TRIG_HIGH_LVL  = 2'b01,
        TRIG_FALL_EDGE = 2'b10,
        TRIG_RISE_EDGE = 2'b11
    } trig_e;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] mode_i,
    input  logic       clr_i,
    output logic       req_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic pend;
    } cell_t;

    cell_t st_d, st_q;
    trig_e mode;
    logic  edge_hit;

    always_comb begin
        mode     = trig_e'(mode_i);
        st_d     = st_q;
        st_d.s1  = pin_i;
        st_d.s2  = st_q.s1;
        st_d.prev = st_q.s2;
        case (mode)
            TRIG_RISE_EDGE: edge_hit = st_q.s2 & ~st_q.prev;
            TRIG_FALL_EDGE: edge_hit = ~st_q.s2 & st_q.prev;
            default:        edge_hit = 1'b0;
        endcase
        st_d.pend = edge_hit | (st_q.pend & ~clr_i);
        case (mode)
            TRIG_LOW_LVL:  req_o = ~st_q.s2;
            TRIG_HIGH_LVL: req_o = st_q.s2;
            default:       req_o = st_q.pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pend) |-> $past(clr_i));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int IW     = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        elig_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output logic                      any_o,
    output logic [IW-1:0]             idx_o
);
    logic [PRIO_W-1:0] best;

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        any_o = 1'b0;
        best  = '0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] >= best)) begin
                any_o = 1'b1;
                best  = prio_i[i*PRIO_W +: PRIO_W];
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] data_i,
    output logic [PRIO_W-1:0] top_o,
    output logic              busy_o
);
    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] slot;
        logic [CW-1:0]                cnt;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end else if (push_i && st_q.cnt < CW'(DEPTH)) begin
            st_d.slot[AW'(st_q.cnt)] = data_i;
            st_d.cnt = st_q.cnt + CW'(1);
        end
        busy_o = (st_q.cnt != '0);
        top_o  = busy_o ? st_q.slot[AW'(st_q.cnt - CW'(1))] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    stack_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |-> st_q.cnt < CW'(DEPTH));

    // R9
    pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && st_q.cnt > CW'(1)) |=> top_o == $past(st_q.slot[AW'(st_q.cnt - CW'(2))]));
endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc #(
    parameter int NUM_SRC   = 32,
    parameter int PRIO_W    = 3,
    parameter int STK_DEPTH = 8,
    localparam int IW       = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_i,
    input  logic [2*NUM_SRC-1:0]      trig_i,
    input  logic [NUM_SRC-1:0]        mask_i,
    input  logic [PRIO_W*NUM_SRC-1:0] prio_i,
    input  logic                      ack_i,
    input  logic                      eos_i,
    output logic                      irq_o,
    output logic [IW-1:0]             vec_o,
    output logic                      nest_busy_o,
    output logic [PRIO_W-1:0]         nest_lvl_o
);
    typedef struct packed {
        logic          irq;
        logic [IW-1:0] vec;
    } out_t;

    out_t              out_d, out_q;
    logic [NUM_SRC-1:0] req, elig, clr;
    logic              ack_take, win_any, busy;
    logic [IW-1:0]     win_idx;
    logic [PRIO_W-1:0] act_lvl, ack_prio;

    assign ack_take = ack_i & out_q.irq & ~eos_i;
    assign ack_prio = prio_i[out_q.vec*PRIO_W +: PRIO_W];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign clr[g]  = ack_take && (out_q.vec == IW'(g));
        assign elig[g] = req[g] & ~mask_i[g] &
                         (~busy | (prio_i[g*PRIO_W +: PRIO_W] > act_lvl));
        intc_src_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (src_i[g]),
            .mode_i (trig_i[2*g +: 2]),
            .clr_i  (clr[g]),
            .req_o  (req[g])
        );
    end

    intc_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .elig_i (elig),
        .prio_i (prio_i),
        .any_o  (win_any),
        .idx_o  (win_idx)
    );

    intc_lvl_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (ack_take),
        .pop_i  (eos_i),
        .data_i (ack_prio),
        .top_o  (act_lvl),
        .busy_o (busy)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = win_any & ~ack_take;
        if (win_any) out_d.vec = win_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_o       = out_q.irq;
    assign vec_o       = out_q.vec;
    assign nest_busy_o = busy;
    assign nest_lvl_o  = act_lvl;

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> !out_q.irq);

    // R7
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> busy && act_lvl == $past(ack_prio));

    // R8
    preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.irq && busy && $stable(prio_i)) |->
            prio_i[out_q.vec*PRIO_W +: PRIO_W] > act_lvl);

    // R4
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.irq |-> ((($past(mask_i)) >> out_q.vec) & NUM_SRC'(1)) == '0);
endmodule

// File: tb/prio_nest_intc_test.sv
module prio_nest_intc_test;
    localparam int N = 32;
    localparam int PW = 3;
    localparam int SETTLE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    src = '0;
    logic [2*N-1:0]  trig = {N{2'b01}};
    logic [N-1:0]    mask = '0;
    logic [PW*N-1:0] prio = '0;
    logic ack = 1'b0, eos = 1'b0;
    logic irq, busy;
    logic [4:0] vec;
    logic [PW-1:0] lvl;

    int total = 0, bad = 0;
    bit done = 0;

    bit       m_pend [N];
    int       m_stk [8];
    int       m_dep = 0;

    prio_nest_intc uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .trig_i(trig), .mask_i(mask),
        .prio_i(prio), .ack_i(ack), .eos_i(eos), .irq_o(irq), .vec_o(vec),
        .nest_busy_o(busy), .nest_lvl_o(lvl)
    );

    always #2 clk = ~clk;

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic int p_of(int i);
        return int'(prio[i*PW +: PW]);
    endfunction

    task automatic expect_out(output bit e_irq, output int e_vec);
        int best;
        e_irq = 0; e_vec = 0; best = 0;
        for (int i = N - 1; i >= 0; i--) begin
            bit r;
            case (trig[2*i +: 2])
                2'b00:   r = !src[i];
                2'b01:   r = src[i];
                default: r = m_pend[i];
            endcase
            if (r && !mask[i] && (m_dep == 0 || p_of(i) > m_stk[m_dep-1]) &&
                (!e_irq || p_of(i) >= best)) begin
                e_irq = 1; best = p_of(i); e_vec = i;
            end
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        bit e_irq; int e_vec;
        expect_out(e_irq, e_vec);
        chk(req, "irq", int'(irq), int'(e_irq));
        if (e_irq) chk(req, "vec", int'(vec), e_vec);
        chk(req, "busy", int'(busy), int'(m_dep != 0));
        chk(req, "lvl", int'(lvl), m_dep != 0 ? m_stk[m_dep-1] : 0);
    endtask

    task automatic set_src(int i, bit v);
        bit old = src[i];
        if (trig[2*i +: 2] == 2'b11 && !old && v) m_pend[i] = 1;
        if (trig[2*i +: 2] == 2'b10 && old && !v) m_pend[i] = 1;
        src[i] = v;
        wait_n(SETTLE);
    endtask

    task automatic do_pulse(bit a, bit e);
        bit e_irq; int e_vec;
        expect_out(e_irq, e_vec);
        if (e && m_dep != 0) m_dep--;
        else if (a && !e && e_irq) begin
            m_stk[m_dep] = p_of(e_vec);
            m_dep++;
            m_pend[e_vec] = 0;
        end
        ack = a; eos = e;
        wait_n(1);
        ack = 0; eos = 0;
        wait_n(SETTLE);
    endtask

    task automatic cfg(int i, int t, bit mk, int p);
        trig[2*i +: 2] = 2'(t);
        mask[i] = mk;
        prio[i*PW +: PW] = PW'(p);
        wait_n(SETTLE);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        for (int i = 0; i < N; i++) m_pend[i] = 0;
        wait_n(3);
        chk("R1", "irq in reset", int'(irq), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        wait_n(SETTLE);
        check_all("R1");

        // R2 level, both polarities
        cfg(5, 1, 0, 2);
        set_src(5, 1); check_all("R2");
        chk("R2", "vec5", int'(vec), 5);
        set_src(5, 0); check_all("R2");
        chk("R2", "irq drop", int'(irq), 0);
        src[6] = 1; cfg(6, 0, 0, 1); check_all("R2");
        set_src(6, 0); check_all("R2");
        chk("R2", "low level vec", int'(vec), 6);
        set_src(6, 1); check_all("R2");

        // R10 latency: level source visible after three edges
        cfg(7, 1, 0, 3);
        src[7] = 1;
        wait_n(3);
        chk("R10", "level latency", int'(irq), 1);
        set_src(7, 0);

        // R3 edge latch and clear on ack
        cfg(10, 3, 0, 4);
        set_src(10, 1); set_src(10, 0); check_all("R3");
        chk("R3", "pend held", int'(irq), 1);
        do_pulse(1, 0); check_all("R3");
        chk("R7", "lvl after ack", int'(lvl), 4);
        do_pulse(0, 1); check_all("R3");
        chk("R3", "cleared", int'(irq), 0);

        // R4 masked edge retained
        cfg(12, 2, 1, 5);
        set_src(12, 1); set_src(12, 0); check_all("R4");
        chk("R4", "masked", int'(irq), 0);
        cfg(12, 2, 0, 5); check_all("R4");
        chk("R4", "released vec", int'(vec), 12);
        do_pulse(1, 0); do_pulse(0, 1); check_all("R4");

        // R5 / R6 arbitration
        cfg(20, 1, 0, 3); cfg(9, 1, 0, 6); cfg(25, 1, 0, 6);
        src[20] = 1; src[25] = 1; wait_n(SETTLE); check_all("R5");
        chk("R5", "higher prio", int'(vec), 25);
        set_src(9, 1); check_all("R6");
        chk("R6", "tie lowest", int'(vec), 9);

        // R8 nesting
        do_pulse(1, 0); check_all("R8");
        chk("R8", "equal blocked", int'(irq), 0);
        cfg(20, 1, 0, 7); check_all("R8");
        chk("R8", "higher preempts", int'(vec), 20);
        do_pulse(1, 0); check_all("R8");
        do_pulse(0, 1); check_all("R9");
        chk("R9", "restored lvl", int'(lvl), 6);

        // R9 corner cases
        do_pulse(1, 1); check_all("R9");
        src[20] = 0; src[25] = 0; src[9] = 0; wait_n(SETTLE);
        do_pulse(0, 1); check_all("R9");
        do_pulse(0, 1); check_all("R9");
        do_pulse(1, 0); check_all("R9");

        // random phase
        seed = $urandom(1234);
        for (int n = 0; n < 900; n++) begin
            int op = $urandom_range(0, 9);
            int i  = $urandom_range(0, N - 1);
            if (op <= 4) set_src(i, ~src[i]);
            else if (op == 5) cfg(i, $urandom_range(0, 3), ($urandom_range(0, 3) == 0), $urandom_range(0, 7));
            else if (op <= 7) do_pulse(1, 0);
            else do_pulse(0, 1);
            check_all(op <= 4 ? "R3" : (op == 5 ? "R5" : "R8"));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule